// File: doc/BRIEF.md
# Multiplexed-Bus ROM and Dual I/O Port Peripheral

This block sits on the multiplexed address/data bus of an 8-bit microcontroller. While the address strobe is high, it captures the low address byte, three high address bits, the memory/IO space select and two chip enables of opposite polarity. The captured enables decide whether the block takes part in the bus cycles that follow.

A selected block answers reads from one of two sources. One is a 2048-byte read-only array, whose contents come from a parameter. The other is a pair of 8-bit general-purpose ports, whose pin directions are set per bit. Port writes use a separate I/O-write strobe. A second read strobe reaches the ports directly, without the space select.

Each tri-state pin is split into a data-out and an output-enable signal. A wait line is pulled low from the select cycle until one clock edge after the strobe falls. At all other times the wait line floats.

Top module: `mbr_periph`

## Requirements
- R1: The block captures the low address, high address, space select and enables at every rising clock edge where ale_i is high. While ale_i is low, changes on those inputs have no effect.
- R2: The block is selected only if ce1_ni was 0 and ce2_i was 1 at capture. When it is not selected, ad_oe_o stays 0.
- R3: When selected with space select 0 captured, rd_ni=0 and ior_ni=1, the block drives ad_oe_o=1. ad_o then carries image byte ((lo + 37*hi) mod 256) XOR 0xA5, where lo is the 8 low address bits and hi is the 3 high bits.
- R4: When selected, ior_ni=0 or (rd_ni=0 with space select 1 captured) returns register data on ad_o with ad_oe_o=1. When rd_ni and ior_ni are both 1, ad_oe_o=0.
- R5: When selected with iow_ni=0 at a rising edge, ad_i is written into the register decoded from the captured address. The captured space select plays no part in this.
- R6: Decode uses captured low bits [1:0] only: 00 is port A output latch, 01 is port B output latch, 10 is port A direction, 11 is port B direction. Low bits [7:2] and the high bits are ignored.
- R7: pa_oe_o/pb_oe_o equal the direction registers (1 = output). pa_o/pb_o equal the output latches.
- R8: A port read returns the output latch bit where the direction bit is 1 and the pin input bit where it is 0. A read of either direction register returns 0x00.
- R9: rst_ni low clears both direction registers, both output latches and the captured select, asynchronously.
- R10: ready_oe_o is 1 while ale_i=1, ce1_ni=0 and ce2_i=1. It is also 1 for the one clock period after a rising edge where that held, and 0 otherwise. ready_o is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ale_i | input | 1 | Address strobe |
| ad_i | input | 8 | Multiplexed bus, input side |
| ad_o | output | 8 | Multiplexed bus, output data |
| ad_oe_o | output | 1 | Multiplexed bus output enable |
| addr_hi_i | input | 3 | High address bits |
| ce1_ni | input | 1 | Chip enable, active low |
| ce2_i | input | 1 | Chip enable, active high |
| io_sel_i | input | 1 | Space select: 1 = I/O, 0 = memory |
| rd_ni | input | 1 | Read strobe, active low |
| ior_ni | input | 1 | I/O read strobe, active low |
| iow_ni | input | 1 | I/O write strobe, active low |
| ready_o | output | 1 | Wait line data (always 0) |
| ready_oe_o | output | 1 | Wait line output enable |
| pa_i | input | 8 | Port A pin inputs |
| pa_o | output | 8 | Port A pin outputs |
| pa_oe_o | output | 8 | Port A pin output enables |
| pb_i | input | 8 | Port B pin inputs |
| pb_o | output | 8 | Port B pin outputs |
| pb_oe_o | output | 8 | Port B pin output enables |

## Verification
A wrong captured address or select becomes visible on the first read strobe after the address phase: ad_o carries the wrong byte, or ad_oe_o takes the wrong level. A corrupted direction or latch register shows at once on the pin outputs and enables, and again on the next port read. A wrong wait-line state shows on ready_oe_o in the same clock period. The bench model mirrors the visible state and compares every output on every clock, so such a fault is reported within one cycle of becoming observable.

// File: rtl/mbr_pkg.sv
package mbr_pkg;
  localparam int DATA_W    = 8;
  localparam int LO_W      = 8;
  localparam int HI_W      = 3;
  localparam int ROM_AW    = LO_W + HI_W;
  localparam int ROM_DEPTH = 1 << ROM_AW;
  localparam int NUM_PORTS = 2;
  localparam int ROM_MUL   = 37;
  localparam logic [DATA_W-1:0] ROM_XOR = 8'hA5;

  typedef logic [DATA_W-1:0] rom_img_t [ROM_DEPTH];

  typedef enum logic [1:0] {
    REG_LAT_A = 2'b00,
    REG_LAT_B = 2'b01,
    REG_DIR_A = 2'b10,
    REG_DIR_B = 2'b11
  } reg_sel_e;

  function automatic rom_img_t default_rom_image();
    rom_img_t img;
    for (int a = 0; a < ROM_DEPTH; a++) begin
      img[a] = DATA_W'((a % (1 << LO_W)) + (a / (1 << LO_W)) * ROM_MUL) ^ ROM_XOR;
    end
    return img;
  endfunction
endpackage

// File: rtl/mbr_addr_latch.sv
module mbr_addr_latch
  import mbr_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ale_i,
  input  logic [LO_W-1:0] ad_i,
  input  logic [HI_W-1:0] addr_hi_i,
  input  logic            io_sel_i,
  input  logic            ce1_ni,
  input  logic            ce2_i,
  output logic [LO_W-1:0] lo_q_o,
  output logic [HI_W-1:0] hi_q_o,
  output logic            io_q_o,
  output logic            sel_q_o,
  output logic            ready_oe_o
);
  logic ce_now;
  logic rdy_hold_q;

  assign ce_now = ~ce1_ni & ce2_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q_o  <= '0;
      hi_q_o  <= '0;
      io_q_o  <= 1'b0;
      sel_q_o <= 1'b0;
    end else if (ale_i) begin
      lo_q_o  <= ad_i;
      hi_q_o  <= addr_hi_i;
      io_q_o  <= io_sel_i;
      sel_q_o <= ce_now;
    end
  end

  // wait line stays low one clock past the strobe
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdy_hold_q <= 1'b0;
    else         rdy_hold_q <= ale_i & ce_now;
  end

  assign ready_oe_o = (ale_i & ce_now) | rdy_hold_q;

  AST_LATCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ale_i |=> ($stable(sel_q_o) && $stable(lo_q_o) && $stable(io_q_o))); // R1
  AST_SEL_NEEDS_CE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sel_q_o) |-> $past(ale_i && !ce1_ni && ce2_i)); // R2
  AST_RDY_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ale_i ##1 !ale_i) |-> !ready_oe_o); // R10
endmodule

// File: rtl/mbr_rom.sv
module mbr_rom
  import mbr_pkg::*;
#(
  parameter rom_img_t IMAGE = default_rom_image()
) (
  input  logic [ROM_AW-1:0] addr_i,
  output logic [DATA_W-1:0] rdata_o
);
  assign rdata_o = IMAGE[addr_i];
endmodule

// File: rtl/mbr_port.sv
module mbr_port
  import mbr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_lat_i,
  input  logic              wr_dir_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] pin_i,
  output logic [DATA_W-1:0] pin_o,
  output logic [DATA_W-1:0] pin_oe_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] lat_q;
  logic [DATA_W-1:0] dir_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q <= '0;
      dir_q <= '0;
    end else begin
      if (wr_lat_i) lat_q <= wdata_i;
      if (wr_dir_i) dir_q <= wdata_i;
    end
  end

  assign pin_o    = lat_q;
  assign pin_oe_o = dir_q;
  assign rdata_o  = (lat_q & dir_q) | (pin_i & ~dir_q);

  AST_LAT_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lat_i |=> pin_o == $past(wdata_i)); // R5
  AST_DIR_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_dir_i |=> pin_oe_o == $past(wdata_i)); // R5
  AST_LAT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_lat_i |=> $stable(pin_o)); // R6
endmodule

// File: rtl/mbr_periph.sv
module mbr_periph
  import mbr_pkg::*;
#(
  parameter rom_img_t ROM_IMAGE = default_rom_image()
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ale_i,
  input  logic [LO_W-1:0]   ad_i,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe_o,
  input  logic [HI_W-1:0]   addr_hi_i,
  input  logic              ce1_ni,
  input  logic              ce2_i,
  input  logic              io_sel_i,
  input  logic              rd_ni,
  input  logic              ior_ni,
  input  logic              iow_ni,
  output logic              ready_o,
  output logic              ready_oe_o,
  input  logic [DATA_W-1:0] pa_i,
  output logic [DATA_W-1:0] pa_o,
  output logic [DATA_W-1:0] pa_oe_o,
  input  logic [DATA_W-1:0] pb_i,
  output logic [DATA_W-1:0] pb_o,
  output logic [DATA_W-1:0] pb_oe_o
);
  logic [LO_W-1:0]   lo_q;
  logic [HI_W-1:0]   hi_q;
  logic              io_q;
  logic              sel_q;
  logic [DATA_W-1:0] rom_data;
  logic              io_read;
  logic              wr_en;
  reg_sel_e          reg_sel;
  logic [DATA_W-1:0] port_data;

  logic [NUM_PORTS-1:0][DATA_W-1:0] pin_in, pin_out, pin_oe, prt_rdata;

  mbr_addr_latch u_latch (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ale_i      (ale_i),
    .ad_i       (ad_i),
    .addr_hi_i  (addr_hi_i),
    .io_sel_i   (io_sel_i),
    .ce1_ni     (ce1_ni),
    .ce2_i      (ce2_i),
    .lo_q_o     (lo_q),
    .hi_q_o     (hi_q),
    .io_q_o     (io_q),
    .sel_q_o    (sel_q),
    .ready_oe_o (ready_oe_o)
  );

  mbr_rom #(.IMAGE(ROM_IMAGE)) u_rom (
    .addr_i  ({hi_q, lo_q}),
    .rdata_o (rom_data)
  );

  assign reg_sel = reg_sel_e'(lo_q[1:0]);
  assign wr_en   = sel_q & ~iow_ni;
  assign pin_in  = {pb_i, pa_i};

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
    logic hit;
    assign hit = (lo_q[0] == g[0]);
    mbr_port u_port (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_lat_i (wr_en & ~lo_q[1] & hit),
      .wr_dir_i (wr_en & lo_q[1] & hit),
      .wdata_i  (ad_i),
      .pin_i    (pin_in[g]),
      .pin_o    (pin_out[g]),
      .pin_oe_o (pin_oe[g]),
      .rdata_o  (prt_rdata[g])
    );
  end

  assign pa_o    = pin_out[0];
  assign pa_oe_o = pin_oe[0];
  assign pb_o    = pin_out[1];
  assign pb_oe_o = pin_oe[1];

  always_comb begin
    unique case (reg_sel)
      REG_LAT_A: port_data = prt_rdata[0];
      REG_LAT_B: port_data = prt_rdata[1];
      default:   port_data = '0;
    endcase
  end

  // I/O read strobe overrides the captured space select
  assign io_read = ~ior_ni | io_q;
  assign ad_oe_o = sel_q & (~rd_ni | ~ior_ni);
  assign ad_o    = io_read ? port_data : rom_data;
  assign ready_o = 1'b0;

  AST_DESEL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_q |-> !ad_oe_o); // R2
  AST_BUS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_ni && ior_ni) |-> !ad_oe_o); // R4
  AST_DIR_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ad_oe_o && io_read && lo_q[1]) |-> ad_o == '0); // R8
endmodule

// File: tb/mbr_periph_tb.sv
`timescale 1ns/1ps
module mbr_periph_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ale = 1'b0, ce1n = 1'b1, ce2 = 1'b0, iom = 1'b0;
  logic rd_n = 1'b1, ior_n = 1'b1, iow_n = 1'b1;
  logic [7:0] ad_i = '0, pa_i = '0, pb_i = '0;
  logic [2:0] hi_i = '0;
  logic [7:0] ad_o, pa_o, pa_oe, pb_o, pb_oe;
  logic ad_oe, rdy, rdy_oe;

  int checks = 0, fails = 0;
  bit cmp_on = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mbr_periph dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ale_i(ale), .ad_i(ad_i), .ad_o(ad_o),
    .ad_oe_o(ad_oe), .addr_hi_i(hi_i), .ce1_ni(ce1n), .ce2_i(ce2),
    .io_sel_i(iom), .rd_ni(rd_n), .ior_ni(ior_n), .iow_ni(iow_n),
    .ready_o(rdy), .ready_oe_o(rdy_oe), .pa_i(pa_i), .pa_o(pa_o),
    .pa_oe_o(pa_oe), .pb_i(pb_i), .pb_o(pb_o), .pb_oe_o(pb_oe)
  );

  // reference model state
  int m_lo, m_hi, m_sel, m_io, m_rdy;
  int m_lat [2];
  int m_dir [2];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lo = 0; m_hi = 0; m_sel = 0; m_io = 0; m_rdy = 0;
      m_lat[0] = 0; m_lat[1] = 0; m_dir[0] = 0; m_dir[1] = 0;
    end else begin
      if (m_sel != 0 && !iow_n) begin
        if (m_lo % 4 < 2) m_lat[m_lo % 2] = ad_i;
        else              m_dir[m_lo % 2] = ad_i;
      end
      m_rdy = (ale && !ce1n && ce2) ? 1 : 0;
      if (ale) begin
        m_lo = ad_i; m_hi = hi_i; m_io = iom;
        m_sel = (!ce1n && ce2) ? 1 : 0;
      end
    end
  end

  function automatic int rom_byte(int a);
    return (((a % 256) + (a / 256) * 37) % 256) ^ 165;
  endfunction

  function automatic int port_val(int idx, int pins);
    return (m_lat[idx] & m_dir[idx]) | (pins & ~m_dir[idx] & 255);
  endfunction

  function automatic int exp_data();
    if (!ior_n || m_io != 0) begin
      if (m_lo % 4 >= 2) return 0;
      return port_val(m_lo % 2, (m_lo % 2) != 0 ? int'(pb_i) : int'(pa_i));
    end
    return rom_byte(m_hi * 256 + m_lo);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // compare every output on every clock
  always @(negedge clk) begin
    if (cmp_on) begin
      int e_oe, e_roe;
      e_oe  = (m_sel != 0 && (!rd_n || !ior_n)) ? 1 : 0;
      e_roe = ((ale && !ce1n && ce2) || m_rdy != 0) ? 1 : 0;
      chk(int'(ad_oe) == e_oe, "R4 ad_oe", int'(ad_oe), e_oe);
      if (e_oe != 0)
        chk(int'(ad_o) == exp_data(), (!ior_n || m_io != 0) ? "R8 port data" : "R3 rom data",
            int'(ad_o), exp_data());
      chk(int'(rdy_oe) == e_roe, "R10 ready_oe", int'(rdy_oe), e_roe);
      chk(rdy == 1'b0, "R10 ready level", int'(rdy), 0);
      chk(int'(pa_o) == m_lat[0] && int'(pa_oe) == m_dir[0], "R7 port A pins",
          int'({pa_oe, pa_o}), m_dir[0] * 256 + m_lat[0]);
      chk(int'(pb_o) == m_lat[1] && int'(pb_oe) == m_dir[1], "R7 port B pins",
          int'({pb_oe, pb_o}), m_dir[1] * 256 + m_lat[1]);
    end
  end

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic addr_phase(input bit c1n, input bit c2, input bit io, input int a);
    ale = 1'b1; ce1n = c1n; ce2 = c2; iom = io;
    ad_i = 8'(a); hi_i = 3'(a / 256);
    #1;
    chk(rdy_oe == (!c1n && c2), "R10 ready during strobe", int'(rdy_oe), int'(!c1n && c2));
    tick();
    ale = 1'b0;
    // disturb captured inputs after the strobe
    ad_i = ~ad_i; hi_i = ~hi_i; iom = ~iom; ce1n = ~c1n; ce2 = ~c2;
    tick();
  endtask

  task automatic wr_cycle(input int d);
    ad_i = 8'(d); iow_n = 1'b0; tick();
    iow_n = 1'b1; tick();
  endtask

  task automatic rd_expect(input bit use_ior, input int exp, input string tag);
    if (use_ior) ior_n = 1'b0; else rd_n = 1'b0;
    #1;
    chk(ad_oe == 1'b1 && int'(ad_o) == exp, tag, int'(ad_o), exp);
    tick();
    rd_n = 1'b1; ior_n = 1'b1;
    #1;
    chk(ad_oe == 1'b0, "R4 both strobes high", int'(ad_oe), 0);
    tick();
  endtask

  initial begin
    #(5 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    chk(pa_oe == 0 && pb_oe == 0 && pa_o == 0 && pb_o == 0, "R9 reset pins",
        int'(pa_oe | pb_oe | pa_o | pb_o), 0);
    chk(ad_oe == 1'b0, "R9 reset deselected", int'(ad_oe), 0);
    rst_n = 1'b1;
    cmp_on = 1'b1;
    tick();

    // memory read
    addr_phase(1'b0, 1'b1, 1'b0, 'h5A3);
    rd_expect(1'b0, rom_byte('h5A3), "R3 rom read 0x5A3");
    chk(rdy_oe == 1'b0, "R10 ready released", int'(rdy_oe), 0);
    addr_phase(1'b0, 1'b1, 1'b0, 'h000);
    rd_expect(1'b0, rom_byte(0), "R3 rom read 0x000");
    addr_phase(1'b0, 1'b1, 1'b0, 'h7FF);
    rd_expect(1'b0, rom_byte('h7FF), "R1 rom read after disturbing inputs");

    // wrong enable polarities
    addr_phase(1'b1, 1'b1, 1'b0, 'h123);
    rd_n = 1'b0; #1;
    chk(ad_oe == 1'b0, "R2 ce1 inactive", int'(ad_oe), 0);
    rd_n = 1'b1; tick();
    addr_phase(1'b0, 1'b0, 1'b1, 'h123);
    ior_n = 1'b0; iow_n = 1'b0; ad_i = 8'hFF; #1;
    chk(ad_oe == 1'b0, "R2 ce2 inactive", int'(ad_oe), 0);
    tick(); ior_n = 1'b1; iow_n = 1'b1; tick();
    chk(pa_o == 0 && pa_oe == 0, "R2 deselected write ignored", int'(pa_o), 0);

    // direction and latch writes, space select ignored, high bits ignored
    addr_phase(1'b0, 1'b1, 1'b0, 'h7FE);
    wr_cycle('hF0);
    chk(pa_oe == 8'hF0, "R6 dir A via 0x..10", int'(pa_oe), 'hF0);
    addr_phase(1'b0, 1'b1, 1'b0, 'h400);
    wr_cycle('h3C);
    chk(pa_o == 8'h3C, "R5 latch A written", int'(pa_o), 'h3C);
    addr_phase(1'b0, 1'b1, 1'b1, 'h0FD);
    wr_cycle('h5A);
    chk(pb_o == 8'h5A && pa_o == 8'h3C, "R6 latch B only", int'(pb_o), 'h5A);
    addr_phase(1'b0, 1'b1, 1'b1, 'h003);
    wr_cycle('h0F);
    chk(pb_oe == 8'h0F, "R7 dir B enables", int'(pb_oe), 'h0F);

    // port reads both ways
    pa_i = 8'h96; pb_i = 8'hC3;
    addr_phase(1'b0, 1'b1, 1'b1, 'h200);
    rd_expect(1'b0, 'h36, "R8 port A mixed read");
    addr_phase(1'b0, 1'b1, 1'b0, 'h200);
    rd_expect(1'b1, 'h36, "R4 io-read strobe equals select+read");
    addr_phase(1'b0, 1'b1, 1'b1, 'h001);
    rd_expect(1'b0, 'hCA, "R8 port B mixed read");
    addr_phase(1'b0, 1'b1, 1'b1, 'h002);
    rd_expect(1'b0, 0, "R8 dir register reads zero");

    // randomized traffic against the model
    for (int i = 0; i < 3000; i++) begin
      ale = 1'($urandom_range(0, 3) == 0);
      ce1n = 1'($urandom_range(0, 4) == 0);
      ce2 = 1'($urandom_range(0, 4) != 0);
      iom = 1'($urandom); ad_i = 8'($urandom); hi_i = 3'($urandom);
      rd_n = 1'($urandom); ior_n = 1'($urandom); iow_n = 1'($urandom_range(0, 3) != 0);
      pa_i = 8'($urandom); pb_i = 8'($urandom);
      if (i == 2000) rst_n = 1'b0;
      if (i == 2003) rst_n = 1'b1;
      tick();
      if (i == 2001)
        chk(pa_oe == 0 && pb_oe == 0 && pa_o == 0 && pb_o == 0, "R9 reset mid-run",
            int'(pa_oe | pb_oe | pa_o | pb_o), 0);
    end

    cmp_on = 1'b0;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule